// File: doc/BRIEF.md
# Legacy Interrupt Pending and Enable Register

This block gathers four level-sensitive legacy interrupt lines and eight bus-error conditions into one 32-bit control word. Each legacy line has a sticky pending bit and an enable bit. Each error condition has an enable bit. All enabled sources are merged into one registered interrupt output that feeds a parent interrupt controller. Software reads the word to find which lines are pending. It sets an enable bit to let a source through, and it acknowledges a legacy line by writing a one to that line's pending bit.

The word also holds a seven-bit field of request-line priorities and a four-bit wait value. The block only stores these fields and reads them back. Writes use a 4-bit byte-lane enable, so a halfword write to the upper half can disable all lines and acknowledge them in one access. Reads are combinational from the stored state.

Top module: `intx_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `rd_data` reads 0x00000000 and `irq_o` is low.
- R2: Line `intx_in[i]` maps to pending bit 28+i (line A at bit 28, line D at bit 31). A line that is high on a clock edge sets its pending bit from that edge on. The pending bit stays set while the line is high, even when software writes a one to it in the same cycle (set wins over clear).
- R3: A write with lane 3 enabled clears pending bit 28+i when `wr_data[28+i]` is one and the line is low. Writing a zero to a pending bit, or making no write at all, leaves that bit unchanged.
- R4: Bits 25..22 enable lines D..A (line A at bit 22; a one means enabled). The bits are writable and read back, and a pending line reaches `irq_o` only while its enable bit is one.
- R5: `err_in` bits 7..0 are, in order: command error, parity error, master abort received, target abort received, target abort sent, retry limit reached, system error received, parity error received. Their enable bits are 27, 26, 21, 20, 19, 18, 17 and 16. An error input that is high reaches `irq_o` only while its enable bit is one. Error inputs are not latched.
- R6: `irq_o` is registered. After each edge it equals the OR, over all sources, of (pending or error level) AND enable, as sampled on that edge.
- R7: Bits 14..8 (priority) and bits 3..0 (wait value) are writable, read back exactly as written, and have no effect on `irq_o`.
- R8: Bits 15 and 7..4 always read as zero, and writing to them has no effect.
- R9: A write updates only the bytes whose `wr_be` bit is set (`wr_be[k]` covers bits 8k+7..8k). Other bytes, including the acknowledge bits in byte 3, are left untouched.
- R10: A write with `wr_be`=4'b1100 and upper halfword 0xF000 does two things in one access. It clears bits 31..16 (every pending bit whose line is low, and every legacy and error enable), and `irq_o` is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| intx_in | input | 4 | Level-sensitive legacy interrupt lines, line A in bit 0 |
| err_in | input | 8 | Bus error condition levels |
| rd_data | output | 32 | Current control word |
| irq_o | output | 1 | Merged interrupt to the parent controller |

## Verification
A write or a line level sampled on edge k shows up in `rd_data` right after edge k, because there is one register on that path. A pending bit reaches `irq_o` one edge later, at k+1. An error level or an enable change sampled at edge k affects `irq_o` in the way R6 describes. The bench drives inputs on falling edges and keeps a behavioural model that it updates on each rising edge from the same inputs. On every falling edge it compares `rd_data` and `irq_o` with that model. The directed checks count whole cycles from the write or pulse to the point where each result is due, and they sample on the falling edge of that cycle.

// File: rtl/intx_irq_pkg.sv
package intx_irq_pkg;

    localparam int REG_W   = 32;
    localparam int LANE_W  = 8;
    localparam int N_LANE  = REG_W / LANE_W;
    localparam int N_INTX  = 4;
    localparam int N_ERR_H = 2;
    localparam int N_ERR_L = 6;
    localparam int N_ERR   = N_ERR_H + N_ERR_L;
    localparam int PRIO_W  = 7;
    localparam int WAIT_W  = 4;

    // Bit positions software decodes
    localparam int POS_PEND  = 28;
    localparam int POS_ERR_H = 26;
    localparam int POS_EN    = 22;
    localparam int POS_ERR_L = 16;
    localparam int POS_PRIO  = 8;
    localparam int POS_WAIT  = 0;

    typedef struct packed {
        logic [N_INTX-1:0]  pend;
        logic [N_ERR_H-1:0] err_en_h;
        logic [N_INTX-1:0]  line_en;
        logic [N_ERR_L-1:0] err_en_l;
        logic               gap_hi;
        logic [PRIO_W-1:0]  prio;
        logic [3:0]         gap_lo;
        logic [WAIT_W-1:0]  wait_v;
    } ctl_word_t;

    function automatic logic [N_ERR-1:0] err_enables(input ctl_word_t w);
        return {w.err_en_h, w.err_en_l};
    endfunction

endpackage

// File: rtl/cfg_field.sv
module cfg_field #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bit_we,
    input  logic [W-1:0] bit_d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (bit_we[i])
                q[i] <= bit_d[i];
        end
    end
endmodule

// File: rtl/intx_pend.sv
module intx_pend #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[i] <= 1'b0;
            else if (line_i[i])
                pend_o[i] <= 1'b1;
            else if (ack_i[i])
                pend_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic any_live;
    assign any_live = |(src_i & en_i);

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= any_live;
    end
endmodule

// File: rtl/intx_irq_ctrl.sv
module intx_irq_ctrl
    import intx_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    input  logic [3:0]  intx_in,
    input  logic [7:0]  err_in,
    output logic [31:0] rd_data,
    output logic        irq_o
);
    localparam int N_SRC = N_INTX + N_ERR;

    logic [REG_W-1:0] bit_we;
    for (genvar b = 0; b < REG_W; b++) begin : g_we
        assign bit_we[b] = wr_en & wr_be[b / LANE_W];
    end

    ctl_word_t word;

    intx_pend #(.N(N_INTX)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .line_i (intx_in),
        .ack_i  (bit_we[POS_PEND +: N_INTX] & wr_data[POS_PEND +: N_INTX]),
        .pend_o (word.pend)
    );

    cfg_field #(.W(N_ERR_H)) u_err_h (
        .clk(clk), .rst(rst),
        .bit_we(bit_we[POS_ERR_H +: N_ERR_H]),
        .bit_d (wr_data[POS_ERR_H +: N_ERR_H]),
        .q     (word.err_en_h)
    );

    cfg_field #(.W(N_INTX)) u_line_en (
        .clk(clk), .rst(rst),
        .bit_we(bit_we[POS_EN +: N_INTX]),
        .bit_d (wr_data[POS_EN +: N_INTX]),
        .q     (word.line_en)
    );

    cfg_field #(.W(N_ERR_L)) u_err_l (
        .clk(clk), .rst(rst),
        .bit_we(bit_we[POS_ERR_L +: N_ERR_L]),
        .bit_d (wr_data[POS_ERR_L +: N_ERR_L]),
        .q     (word.err_en_l)
    );

    cfg_field #(.W(PRIO_W)) u_prio (
        .clk(clk), .rst(rst),
        .bit_we(bit_we[POS_PRIO +: PRIO_W]),
        .bit_d (wr_data[POS_PRIO +: PRIO_W]),
        .q     (word.prio)
    );

    cfg_field #(.W(WAIT_W)) u_wait (
        .clk(clk), .rst(rst),
        .bit_we(bit_we[POS_WAIT +: WAIT_W]),
        .bit_d (wr_data[POS_WAIT +: WAIT_W]),
        .q     (word.wait_v)
    );

    assign word.gap_hi = 1'b0;
    assign word.gap_lo = '0;

    irq_merge #(.N(N_SRC)) u_merge (
        .clk   (clk),
        .rst   (rst),
        .src_i ({word.pend, err_in}),
        .en_i  ({word.line_en, err_enables(word)}),
        .irq_o (irq_o)
    );

    assign rd_data = word;

    logic unused_bits;
    assign unused_bits = ^{bit_we[15], bit_we[7:4], wr_data[15], wr_data[7:4]};
endmodule

// File: rtl/intx_irq_chk.sv
module intx_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [3:0]  wr_be,
    input logic [31:0] wr_data,
    input logic [3:0]  intx_in,
    input logic [7:0]  err_in,
    input logic [31:0] rd_data,
    input logic        irq_o
);
    logic unused_chk;
    assign unused_chk = ^{wr_be[1:0], wr_data[15:0]};

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == 32'h0 && !irq_o)); // R1

    for (genvar i = 0; i < 4; i++) begin : g_line
        AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(intx_in[i])) |-> rd_data[28+i]); // R2

        AST_ACK_ONLY_BY_ONE: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(rd_data[28+i])
             && !$past(wr_en && wr_be[3] && wr_data[28+i])) |-> rd_data[28+i]); // R3
    end

    AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> irq_o == $past((|(rd_data[31:28] & rd_data[25:22]))
                                    || (|(err_in & {rd_data[27:26], rd_data[21:16]})))); // R6

    AST_GAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[15] == 1'b0 && rd_data[7:4] == 4'h0); // R8

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(wr_en)) |-> rd_data[27:0] == $past(rd_data[27:0])); // R9

    AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en && wr_be[3:2] == 2'b11 && wr_data[31:16] == 16'hF000
                              && intx_in == 4'h0)) |-> rd_data[31:16] == 16'h0); // R10
endmodule

bind intx_irq_ctrl intx_irq_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .intx_in(intx_in), .err_in(err_in), .rd_data(rd_data), .irq_o(irq_o)
);

// File: tb/sim_intx_irq_ctrl.sv
module sim_intx_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic [3:0]  intx_in = 4'h0;
    logic [7:0]  err_in = 8'h0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    intx_irq_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .intx_in(intx_in), .err_in(err_in), .rd_data(rd_data), .irq_o(irq_o)
    );

    // Behavioural reference, built from the requirements
    localparam logic [31:0] STORE_MASK = 32'h0FFF_7F0F;
    logic [31:0] m_cfg  = 32'h0;
    logic [3:0]  m_pend = 4'h0;
    logic        m_irq  = 1'b0;

    always @(posedge clk) begin
        logic       nxt_irq;
        logic [3:0] ack;
        if (rst) begin
            m_cfg = 32'h0; m_pend = 4'h0; m_irq = 1'b0;
        end else begin
            nxt_irq = ((m_pend & m_cfg[25:22]) != 0)
                   || ((err_in & {m_cfg[27:26], m_cfg[21:16]}) != 0);
            ack = (wr_en && wr_be[3]) ? wr_data[31:28] : 4'h0;
            for (int b = 0; b < 4; b++)
                if (wr_en && wr_be[b])
                    m_cfg[b*8 +: 8] = wr_data[b*8 +: 8] & STORE_MASK[b*8 +: 8];
            m_pend = (m_pend & ~ack) | intx_in;
            m_irq  = nxt_irq;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R9 model word", rd_data, {m_pend, m_cfg[27:0]});
            chk("R6 model irq", {31'h0, irq_o}, {31'h0, m_irq});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0; wr_data = 32'h0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] low_keep;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 reset irq", {31'h0, irq_o}, 32'h0);

        // R8: only storable bits take ones
        wr(4'hF, 32'hFFFF_FFFF);
        chk("R8 gaps read zero", rd_data, 32'h0FFF_7F0F);
        wr(4'hF, 32'h0);

        // R7: plain fields
        wr(4'b0011, 32'h0000_5A03);
        chk("R7 prio/wait readback", rd_data, 32'h0000_5A03);
        chk("R7 no irq effect", {31'h0, irq_o}, 32'h0);

        // R2: pulse line A
        @(negedge clk); intx_in = 4'b0001;
        tick(1); intx_in = 4'b0000;
        chk("R2 line A sets bit 28", rd_data[31:28], 4'b0001);
        tick(3);
        chk("R2 status sticky", rd_data[31:28], 4'b0001);

        // R3 / R9
        wr(4'b1000, 32'h0000_0000);
        chk("R3 zero write keeps", rd_data[31:28], 4'b0001);
        wr(4'b0111, 32'h1000_5A03);
        chk("R9 lane 3 off keeps status", rd_data[31:28], 4'b0001);
        wr(4'b1000, 32'h1000_0000);
        chk("R3 one write clears", rd_data[31:28], 4'b0000);

        // R2 set wins while line high
        @(negedge clk); intx_in = 4'b0010;
        wr(4'b1000, 32'h2000_0000);
        chk("R2 set wins over ack", rd_data[31:28], 4'b0010);
        @(negedge clk); intx_in = 4'b0000;
        wr(4'b1000, 32'h2000_0000);
        chk("R3 ack after line low", rd_data[31:28], 4'b0000);

        // R4 / R6: enable line A only
        wr(4'b0100, 32'h0040_0000);
        chk("R4 enable readback", rd_data[25:22], 4'b0001);
        @(negedge clk); intx_in = 4'b0010;
        tick(1); intx_in = 4'b0000;
        tick(2);
        chk("R4 disabled line B no irq", {31'h0, irq_o}, 32'h0);
        wr(4'b1000, 32'h2000_0000);
        intx_in = 4'b0001;
        tick(1); intx_in = 4'b0000;
        chk("R6 irq not yet", {31'h0, irq_o}, 32'h0);
        tick(1);
        chk("R6 irq one cycle later", {31'h0, irq_o}, 32'h1);
        wr(4'b1000, 32'h1000_0000);
        chk("R6 irq holds old value", {31'h0, irq_o}, 32'h1);
        tick(1);
        chk("R6 irq drops", {31'h0, irq_o}, 32'h0);

        // R5: master abort received, enable bit 21
        @(negedge clk); err_in = 8'b0010_0000;
        tick(2);
        chk("R5 masked error", {31'h0, irq_o}, 32'h0);
        wr(4'b0100, 32'h0060_0000);
        tick(1);
        chk("R5 enabled error", {31'h0, irq_o}, 32'h1);
        err_in = 8'h00;
        tick(1);
        chk("R5 error not latched", {31'h0, irq_o}, 32'h0);
        wr(4'b1000, 32'h0800_0000);
        err_in = 8'b1000_0000;
        tick(1);
        chk("R5 command error via bit 27", {31'h0, irq_o}, 32'h1);
        err_in = 8'h00;
        tick(1);

        // R10: flush
        wr(4'b1100, 32'h03C0_0000);
        intx_in = 4'b1111;
        tick(1); intx_in = 4'b0000;
        tick(1);
        chk("R10 all pending", rd_data[31:28], 4'hF);
        chk("R10 irq before flush", {31'h0, irq_o}, 32'h1);
        low_keep = rd_data[15:0];
        wr(4'b1100, 32'hF000_0000);
        chk("R10 upper half cleared", {16'h0, rd_data[31:16]}, 32'h0);
        chk("R9 lower half kept", {16'h0, rd_data[15:0]}, {16'h0, low_keep});
        tick(1);
        chk("R10 irq low after flush", {31'h0, irq_o}, 32'h0);

        tick(2);
        finish_run();
    end
endmodule